// File: doc/BRIEF.md
# Write-Enable and Block-Protect Control Register

This block keeps the control byte of a serial memory: a volatile write-enable latch, a register-unlock latch, a three-bit protection code and a protect-enable flag that works together with an external write-protect pin. The bus front end hands it two kinds of event. One is a data byte aimed at the control register address. The other is an attempted write to an array address. For each event the block decides whether to acknowledge it and how its latches change.

Nonvolatile fields can only change after an unlock sequence of three single-byte transfers: 02h, then 06h, then the new value. Each nonvolatile update sets a busy flag for a fixed number of clock cycles, which stands in for the storage write time. While that flag is high the block refuses every write.

The block also decodes the protection code against the presented array address. It drives a combinational permit signal and returns the register byte for reads at any time.

Top module: `wprot_ctrl`

## Requirements
- R1: After reset the register reads 00h, write_permit is 0, nv_busy is 0, and neither acknowledge is asserted.
- R2: While WEL (bit 1) is 0, the only register byte that is acknowledged is 02h. Every other register byte and every array write gets no acknowledge.
- R3: A register write is acknowledged one cycle after its valid. A volatile write (RWEL=0, or bit 1 of the data clear) loads WEL from data bit 1. If data bits 2 and 1 are both set, it also sets RWEL (bit 2). It causes no busy time, so 02h reads back 02h, 06h reads back 06h, and 00h clears WEL.
- R4: With RWEL=1, a byte with bit 2 clear and bit 1 set is a commit. It loads WPEN (bit 7), BP1 (bit 4), BP0 (bit 3) and BP2 (bit 0), clears RWEL, leaves WEL set and holds nv_busy high for BUSY_CYCLES cycles. The sequence 02h, 06h, 02h clears all nonvolatile bits.
- R5: With RWEL=1, a byte with bit 2 set leaves the nonvolatile bits unchanged and RWEL set.
- R6: A register byte with bit 6 or bit 5 set is refused with no acknowledge and no change.
- R7: write_permit is 1 exactly when WEL is 1 and arr_wr_addr lies outside the protected range. The protection code {BP2,BP1,BP0} maps to ranges as follows: 000 none; 001 6000h–7FFFh; 010 4000h–7FFFh; 011 all; 100 0000h–003Fh; 101 0000h–007Fh; 110 0000h–00FFh; 111 0000h–01FFh.
- R8: An array write to a protected address gets no acknowledge and clears RWEL, whatever the pin level. An array write to an unprotected address while WEL=1 is acknowledged.
- R9: While wp_pin is 1 and WPEN is 1, a commit is refused with no acknowledge and no change, and WPEN cannot fall. Array writes to unprotected addresses are still acknowledged. With wp_pin at 0 the same commit is accepted.
- R10: Only the first data byte after xfer_start is considered. A further byte in the same transfer is refused with no change.
- R11: While nv_busy is 1, register and array writes are refused and change nothing.
- R12: Reads return {WPEN, 0, 0, BP1, BP0, RWEL, WEL, BP2}, with bits 6 and 5 always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wp_pin | input | 1 | Hardware write-protect level |
| xfer_start | input | 1 | Pulse marking the start of a new write transfer |
| reg_wr_valid | input | 1 | Data byte for the control register is present |
| reg_wr_data | input | 8 | Register data byte |
| arr_wr_valid | input | 1 | Array write attempt is present |
| arr_wr_addr | input | ADDR_W | Array address under test |
| reg_wr_ack | output | 1 | Register byte accepted (one cycle after valid) |
| arr_wr_ack | output | 1 | Array write accepted (one cycle after valid) |
| write_permit | output | 1 | Combinational permit for arr_wr_addr |
| reg_rd_data | output | 8 | Current register byte |
| nv_busy | output | 1 | Nonvolatile commit in progress |

## Verification
Some rules are checked on every cycle. Busy time blocks acknowledges. A permit requires WEL. An array write without a permit is never acknowledged. The nonvolatile bits change only together with the rising edge of the busy flag. A commit under the pin lock never raises busy, and WPEN never falls while the pin is high. Other behaviour can only be shown by the bench scenarios: the exact unlock-sequence outcomes, the per-code address ranges at their edges, the refusal of a second byte in one transfer, the RWEL clear caused by a protected array write, and the exact busy length.

// File: rtl/wprot_pkg.sv
// Shared types and constants for the write-protect control register.
// Assumes an 8-bit register byte; field positions are fixed by the register format.
package wprot_pkg;

    typedef struct packed {
        logic       wpen;
        logic [2:0] bp;     // {BP2, BP1, BP0}
        logic       rwel;
        logic       wel;
    } ctrl_t;

    localparam logic [7:0] SET_WEL_BYTE = 8'h02;

    // Assemble the readable register byte from the latch state.
    function automatic logic [7:0] pack_reg(input ctrl_t s);
        return {s.wpen, 2'b00, s.bp[1], s.bp[0], s.rwel, s.wel, s.bp[2]};
    endfunction

endpackage

// File: rtl/wprot_decode.sv
// Protection range decoder: tells whether an array address falls in the
// range selected by the 3-bit protection code. Assumes ADDR_W >= PAGE_W + 4.
module wprot_decode #(
    parameter int ADDR_W = 15,
    parameter int PAGE_W = 6
) (
    input  logic [2:0]        bp,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    localparam int LOW_SPANS = 4;

    logic [LOW_SPANS-1:0] low_hit;

    // One comparator per "first 2^k pages" span.
    generate
        for (genvar k = 0; k < LOW_SPANS; k++) begin : g_low
            assign low_hit[k] = (addr[ADDR_W-1:PAGE_W+k] == '0);
        end
    endgenerate

    // Select the range for the current code.
    always_comb begin
        if (bp[2]) begin
            hit = low_hit[bp[1:0]];
        end else begin
            unique case (bp[1:0])
                2'b00:   hit = 1'b0;
                2'b01:   hit = &addr[ADDR_W-1:ADDR_W-2];
                2'b10:   hit = addr[ADDR_W-1];
                default: hit = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/wprot_busy.sv
// Commit busy timer: holds busy high for BUSY_CYCLES cycles after a load pulse.
// Assumes load is never asserted while busy (the register refuses writes then).
module wprot_busy #(
    parameter int BUSY_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic busy
);
    localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

    logic [CNT_W-1:0] cnt;

    // Count down the remaining busy cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= CNT_W'(BUSY_CYCLES);
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);
endmodule

// File: rtl/wprot_regfile.sv
// Control latches and write arbitration. Decides acknowledge, volatile latch
// updates and nonvolatile commits. Assumes register and array events are not
// presented in the same cycle.
module wprot_regfile
    import wprot_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wp_pin,
    input  logic       xfer_start,
    input  logic       reg_wr_valid,
    input  logic [7:0] reg_wr_data,
    input  logic       arr_wr_valid,
    input  logic       arr_prot,
    input  logic       busy,
    output ctrl_t      st,
    output logic       commit,
    output logic       reg_ack,
    output logic       arr_ack
);
    logic byte_seen;
    logic first_byte, data_ok, is_commit, hw_lock;
    logic reg_accept, prot_strike, arr_accept;

    // Classify the current events.
    always_comb begin
        first_byte  = xfer_start | ~byte_seen;
        data_ok     = (reg_wr_data[6:5] == 2'b00);
        is_commit   = st.rwel & ~reg_wr_data[2] & reg_wr_data[1];
        hw_lock     = wp_pin & st.wpen;
        reg_accept  = reg_wr_valid & first_byte & ~busy & data_ok
                    & (st.wel | (reg_wr_data == SET_WEL_BYTE))
                    & ~(is_commit & hw_lock);
        commit      = reg_accept & is_commit;
        prot_strike = arr_wr_valid & arr_prot & ~busy;
        arr_accept  = arr_wr_valid & st.wel & ~arr_prot & ~busy;
    end

    // Track whether the current transfer already delivered its byte.
    always_ff @(posedge clk) begin
        if (!rst_n)            byte_seen <= 1'b1;
        else if (reg_wr_valid) byte_seen <= 1'b1;
        else if (xfer_start)   byte_seen <= 1'b0;
    end

    // Update latches on accepted writes and protected-write strikes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= '0;
        end else begin
            if (commit) begin
                st.wpen <= reg_wr_data[7];
                st.bp   <= {reg_wr_data[0], reg_wr_data[4], reg_wr_data[3]};
                st.rwel <= 1'b0;
                st.wel  <= 1'b1;
            end else if (reg_accept) begin
                st.wel <= reg_wr_data[1];
                if (reg_wr_data[2] & reg_wr_data[1]) st.rwel <= 1'b1;
            end
            if (prot_strike) st.rwel <= 1'b0;
        end
    end

    // Register the acknowledges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_ack <= 1'b0;
            arr_ack <= 1'b0;
        end else begin
            reg_ack <= reg_accept;
            arr_ack <= arr_accept;
        end
    end
endmodule

// File: rtl/wprot_ctrl.sv
// Top of the write-enable / block-protect register. Joins the latch logic,
// the range decoder and the commit timer. Assumes a bus front end that frames
// transfers with xfer_start and presents one event per cycle.
module wprot_ctrl
    import wprot_pkg::*;
#(
    parameter int ADDR_W      = 15,
    parameter int PAGE_W      = 6,
    parameter int BUSY_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wp_pin,
    input  logic              xfer_start,
    input  logic              reg_wr_valid,
    input  logic [7:0]        reg_wr_data,
    input  logic              arr_wr_valid,
    input  logic [ADDR_W-1:0] arr_wr_addr,
    output logic              reg_wr_ack,
    output logic              arr_wr_ack,
    output logic              write_permit,
    output logic [7:0]        reg_rd_data,
    output logic              nv_busy
);
    ctrl_t st;
    logic  arr_prot;
    logic  commit;

    wprot_decode #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_decode (
        .bp   (st.bp),
        .addr (arr_wr_addr),
        .hit  (arr_prot)
    );

    wprot_busy #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (commit),
        .busy  (nv_busy)
    );

    wprot_regfile u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wp_pin       (wp_pin),
        .xfer_start   (xfer_start),
        .reg_wr_valid (reg_wr_valid),
        .reg_wr_data  (reg_wr_data),
        .arr_wr_valid (arr_wr_valid),
        .arr_prot     (arr_prot),
        .busy         (nv_busy),
        .st           (st),
        .commit       (commit),
        .reg_ack      (reg_wr_ack),
        .arr_ack      (arr_wr_ack)
    );

    // Permit and read-back views of the latch state.
    assign write_permit = st.wel & ~arr_prot;
    assign reg_rd_data  = pack_reg(st);
endmodule

// File: rtl/wprot_ctrl_chk.sv
// Checker for wprot_ctrl: cycle-level rules observed at the ports.
// Assumes reset is held for at least two cycles.
module wprot_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wp_pin,
    input logic       reg_wr_valid,
    input logic       arr_wr_valid,
    input logic       reg_wr_ack,
    input logic       arr_wr_ack,
    input logic       write_permit,
    input logic [7:0] reg_rd_data,
    input logic       nv_busy
);
    AST_BUSY_BLOCKS_REG: assert property (@(posedge clk) disable iff (!rst_n)
        (nv_busy && reg_wr_valid) |=> !reg_wr_ack); // R11
    AST_BUSY_BLOCKS_ARR: assert property (@(posedge clk) disable iff (!rst_n)
        (nv_busy && arr_wr_valid) |=> !arr_wr_ack); // R11
    AST_PERMIT_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        write_permit |-> reg_rd_data[1]); // R7
    AST_NO_PERMIT_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_wr_valid && !write_permit) |=> !arr_wr_ack); // R8
    AST_COMMIT_CLEARS_RWEL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nv_busy) |-> (reg_wr_ack && !reg_rd_data[2] && reg_rd_data[1])); // R4
    AST_NV_ONLY_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        ({reg_rd_data[7], reg_rd_data[4:3], reg_rd_data[0]} !=
         $past({reg_rd_data[7], reg_rd_data[4:3], reg_rd_data[0]})) |-> $rose(nv_busy)); // R4
    AST_LOCK_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (wp_pin && reg_rd_data[7] && reg_wr_valid) |=> !$rose(nv_busy)); // R9
    AST_LOCK_HOLDS_WPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (wp_pin && reg_rd_data[7]) |=> reg_rd_data[7]); // R9
endmodule

bind wprot_ctrl wprot_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wp_pin       (wp_pin),
    .reg_wr_valid (reg_wr_valid),
    .arr_wr_valid (arr_wr_valid),
    .reg_wr_ack   (reg_wr_ack),
    .arr_wr_ack   (arr_wr_ack),
    .write_permit (write_permit),
    .reg_rd_data  (reg_rd_data),
    .nv_busy      (nv_busy)
);

// File: tb/wprot_ctrl_bench.sv
module wprot_ctrl_bench;
    localparam int ADDR_W = 15;
    localparam int BUSY   = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wp_pin = 1'b0;
    logic              xfer_start = 1'b0;
    logic              reg_wr_valid = 1'b0;
    logic [7:0]        reg_wr_data = '0;
    logic              arr_wr_valid = 1'b0;
    logic [ADDR_W-1:0] arr_wr_addr = '0;
    logic              reg_wr_ack, arr_wr_ack, write_permit, nv_busy;
    logic [7:0]        reg_rd_data;

    int tests = 0;
    int fails = 0;
    logic       got_ack;
    logic [7:0] got_rd;
    logic       got_permit;

    always #10 clk = ~clk;

    wprot_ctrl #(.ADDR_W(ADDR_W), .PAGE_W(6), .BUSY_CYCLES(BUSY)) u_wprot_ctrl (
        .clk(clk), .rst_n(rst_n), .wp_pin(wp_pin), .xfer_start(xfer_start),
        .reg_wr_valid(reg_wr_valid), .reg_wr_data(reg_wr_data),
        .arr_wr_valid(arr_wr_valid), .arr_wr_addr(arr_wr_addr),
        .reg_wr_ack(reg_wr_ack), .arr_wr_ack(arr_wr_ack),
        .write_permit(write_permit), .reg_rd_data(reg_rd_data), .nv_busy(nv_busy)
    );

    // Vector: {is_arr, value[14:0], exp_ack, exp_rd[7:0], req[3:0]}
    localparam int NVEC = 17;
    localparam logic [28:0] VEC [NVEC] = '{
        {1'b0, 15'h0006, 1'b0, 8'h00, 4'd2},  // R2 06h refused while WEL=0
        {1'b1, 15'h0000, 1'b0, 8'h00, 4'd2},  // R2 array refused while WEL=0
        {1'b0, 15'h0002, 1'b1, 8'h02, 4'd3},  // R3 02h sets WEL
        {1'b1, 15'h1234, 1'b1, 8'h02, 4'd8},  // R8 unprotected array write
        {1'b0, 15'h0006, 1'b1, 8'h06, 4'd3},  // R3 06h sets RWEL
        {1'b0, 15'h0062, 1'b0, 8'h06, 4'd6},  // R6 bit 6 set
        {1'b0, 15'h0026, 1'b0, 8'h06, 4'd6},  // R6 bit 5 set
        {1'b0, 15'h0006, 1'b1, 8'h06, 4'd5},  // R5 bit2 set keeps RWEL
        {1'b0, 15'h000A, 1'b1, 8'h0A, 4'd4},  // R4 commit code 001
        {1'b1, 15'h6000, 1'b0, 8'h0A, 4'd8},  // R8 protected
        {1'b1, 15'h5FFF, 1'b1, 8'h0A, 4'd8},  // R8 just below range
        {1'b0, 15'h0002, 1'b1, 8'h0A, 4'd3},  // R3
        {1'b0, 15'h0006, 1'b1, 8'h0E, 4'd3},  // R3
        {1'b1, 15'h7FFF, 1'b0, 8'h0A, 4'd8},  // R8 strike clears RWEL
        {1'b0, 15'h0006, 1'b1, 8'h0E, 4'd3},  // R3
        {1'b0, 15'h0002, 1'b1, 8'h02, 4'd4},  // R4 02,06,02 clears NV bits
        {1'b0, 15'h0000, 1'b1, 8'h00, 4'd3}   // R3 00h clears WEL
    };

    localparam int NADDR = 14;
    localparam logic [14:0] PROBE [NADDR] = '{
        15'h0000, 15'h003F, 15'h0040, 15'h007F, 15'h0080, 15'h00FF, 15'h0100,
        15'h01FF, 15'h0200, 15'h3FFF, 15'h4000, 15'h5FFF, 15'h6000, 15'h7FFF
    };

    function automatic logic prot_exp(input logic [2:0] c, input logic [14:0] a);
        case (c)
            3'd0: return 1'b0;
            3'd1: return a >= 15'h6000;
            3'd2: return a >= 15'h4000;
            3'd3: return 1'b1;
            3'd4: return a <= 15'h003F;
            3'd5: return a <= 15'h007F;
            3'd6: return a <= 15'h00FF;
            default: return a <= 15'h01FF;
        endcase
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_byte(input logic [7:0] d);
        @(negedge clk);
        reg_wr_valid = 1'b1; reg_wr_data = d;
        @(negedge clk);
        reg_wr_valid = 1'b0;
        got_ack = reg_wr_ack; got_rd = reg_rd_data;
    endtask

    task automatic do_reg(input logic [7:0] d);
        @(negedge clk);
        xfer_start = 1'b1;
        @(negedge clk);
        xfer_start = 1'b0;
        reg_wr_valid = 1'b1; reg_wr_data = d;
        @(negedge clk);
        reg_wr_valid = 1'b0;
        got_ack = reg_wr_ack; got_rd = reg_rd_data;
    endtask

    task automatic do_arr(input logic [14:0] a);
        @(negedge clk);
        arr_wr_valid = 1'b1; arr_wr_addr = a;
        #1 got_permit = write_permit;
        @(negedge clk);
        arr_wr_valid = 1'b0;
        got_ack = arr_wr_ack; got_rd = reg_rd_data;
    endtask

    task automatic wait_idle();
        while (nv_busy) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1 reset state
        chk("R1 rd", reg_rd_data, 8'h00);
        chk("R1 permit", write_permit, 0);
        chk("R1 busy", nv_busy, 0);
        chk("R1 acks", {reg_wr_ack, arr_wr_ack}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 rd after release", reg_rd_data, 8'h00);

        // Table walk
        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][28]) do_arr(VEC[i][27:13]);
            else            do_reg(VEC[i][20:13]);
            chk($sformatf("R%0d vec%0d ack", VEC[i][3:0], i), got_ack, VEC[i][12]);
            chk($sformatf("R%0d vec%0d rd", VEC[i][3:0], i), got_rd, VEC[i][11:4]);
            chk("R12 reserved bits", got_rd[6:5], 0);
            wait_idle();
        end

        // R7 protection ranges for every code
        for (int c = 0; c < 8; c++) begin
            logic [7:0] v;
            v = {3'b000, c[1], c[0], 1'b0, 1'b1, c[2]};
            do_reg(8'h02);
            do_reg(8'h06);
            do_reg(v);
            wait_idle();
            chk("R4 commit readback", got_rd, v);
            for (int j = 0; j < NADDR; j++) begin
                @(negedge clk);
                arr_wr_addr = PROBE[j];
                #1;
                chk($sformatf("R7 code%0d addr%0h", c, PROBE[j]), write_permit,
                    !prot_exp(c[2:0], PROBE[j]));
            end
        end

        // R9 pin lock: WPEN=1, code 100
        do_reg(8'h06);
        do_reg(8'h83);
        wait_idle();
        chk("R9 setup", got_rd, 8'h83);
        wp_pin = 1'b1;
        do_arr(15'h0100);
        chk("R9 unprotected array under lock", got_ack, 1);
        do_arr(15'h0000);
        chk("R8 protected array under lock", got_ack, 0);
        do_reg(8'h06);
        chk("R9 06h under lock", got_rd, 8'h87);
        do_reg(8'h02);
        chk("R9 commit refused ack", got_ack, 0);
        chk("R9 commit refused rd", got_rd, 8'h87);
        chk("R9 no busy", nv_busy, 0);
        wp_pin = 1'b0;
        do_reg(8'h02);
        chk("R9 commit after pin low ack", got_ack, 1);
        chk("R9 commit after pin low rd", got_rd, 8'h02);

        // R4 busy length
        begin
            int cyc;
            cyc = 0;
            while (nv_busy) begin cyc++; @(negedge clk); end
            chk("R4 busy length", cyc, BUSY);
        end

        // R11 writes during busy
        do_reg(8'h06);
        do_reg(8'h02);
        do_reg(8'h00);
        chk("R11 reg write during busy ack", got_ack, 0);
        chk("R11 reg write during busy rd", got_rd, 8'h02);
        do_arr(15'h7000);
        chk("R11 array write during busy", got_ack, 0);
        wait_idle();
        do_arr(15'h7000);
        chk("R11 array write after busy", got_ack, 1);

        // R10 second byte in a transfer
        do_reg(8'h00);
        chk("R3 clear WEL", got_rd, 8'h00);
        do_reg(8'h02);
        chk("R10 first byte", got_ack, 1);
        do_byte(8'h00);
        chk("R10 second byte ack", got_ack, 0);
        chk("R10 second byte rd", got_rd, 8'h02);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule